// File: doc/BRIEF.md
# Network Adapter Bank Mapper

This block is the address decoder and bank-register file of a network adapter that sits in a cartridge slot. It watches the CPU address, data, read/write line and a bus enable that is high during the data phase. From these it produces chip selects for the adapter's firmware ROM, the plugged-in game card (ROM or RAM), a video-memory window and its own control registers. It also produces a 4 KB bank number that forms the upper address lines of whichever memory is selected.

A card-present input steers the $8000-$DFFF range. With a card inserted, that range goes to card ROM. Without one, the same bank numbers go to firmware ROM. Eight control registers repeat across $6000-$6FFF. They hold the switchable card ROM bank, the card RAM bank, the switchable firmware bank and the video window bank. A read of register 2 reports whether a card is absent. The serial registers at indices 0 and 1 are only decoded into a select.

Top module: `netcart_bank_map`

## Requirements
- R1: After reset every bank register is 0, so $7000 gives bank 0, $E000 gives bank 0, $C000/$D000 give banks 0/1 and the video bank output is 0.
- R2: An access to $8000-$BFFF gives bank number A[13:12], that is fixed banks 0 to 3.
- R3: An access to $C000-$DFFF gives bank {reg3[5:1], A12}; bits 7, 6 and 0 of register 3 have no effect.
- R4: An access to $7000-$7FFF gives bank reg4[2:0] and raises card_ram, the RAM/ROM steering line.
- R5: An access to $E000-$EFFF gives bank reg5[2:0] with the firmware select active.
- R6: An access to $F000-$FFFF gives the last bank (all ones, 63 by default) with the firmware select active.
- R7: With a card present, card_cs is active for $7000-$DFFF and fw_cs only for $E000-$FFFF. The two are never active together.
- R8: With no card, card_cs is never active, and fw_cs covers $8000-$FFFF using the same bank numbers.
- R9: Register index is A[2:0] for any address in $6000-$6FFF, so every mirror reaches the same register.
- R10: A read of register 2 drives rd_data = $00 with a card present and $FF without one, with rd_oe high. rd_oe stays low for any other access.
- R11: A write to register 2 sets the video window bank to data[4:0]. vwin_cs is active for $5000-$57FF only.
- R12: A register write takes effect at the clock edge that first sees the enable low after it was high. A held enable does not commit it, and a read cycle changes no register.
- R13: modem_cs is active for register indices 0 and 1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus enable |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_en | input | 1 | Bus data-phase enable |
| card_present | input | 1 | 1 when a game card is inserted |
| bank_out | output | BANK_W | 4 KB bank number (upper address bits) |
| card_cs | output | 1 | Game card select |
| card_ram | output | 1 | Card access targets RAM (1) or ROM (0) |
| fw_cs | output | 1 | Firmware ROM select |
| vwin_cs | output | 1 | Video window select |
| vwin_bank | output | VWIN_W | 1 KB video window bank |
| reg_cs | output | 1 | Control register range select |
| modem_cs | output | 1 | Serial register (index 0/1) select |
| rd_data | output | 8 | Status read data |
| rd_oe | output | 1 | rd_data is valid and should drive the bus |

## Verification
A table of addresses is swept twice with the same nonzero register contents: once with a card present and once without. The first pass separates the card-versus-firmware steering of $8000-$DFFF from the fixed behaviour of $E000-$FFFF. Register 3 is loaded with its ignored bits set, so a wrong field slice shows up as a wrong $C000 bank. Register writes go through different mirrors, and the $C000/$D000 pair tells the A12 bit apart from register bits. Directed tests hold the enable high to show that a write is not committed early, issue a read cycle to show that reads change nothing, and probe the window and register edges at $57FF/$5800 and indices 1/2.

// File: rtl/netcart_pkg.sv
package netcart_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_VWIN,
    RG_REGS,
    RG_CRAM,
    RG_ROMLO,
    RG_ROMSW,
    RG_FWSW,
    RG_FWTOP
  } region_e;

  localparam logic [2:0] IDX_VWIN = 3'd2;
  localparam logic [2:0] IDX_ROMSW = 3'd3;
  localparam logic [2:0] IDX_CRAM = 3'd4;
  localparam logic [2:0] IDX_FWSW = 3'd5;

  function automatic region_e region_of(input logic [15:0] a);
    region_e r;
    r = RG_NONE;
    if (a[15:11] == 5'b01010) r = RG_VWIN;
    else if (a[15:12] == 4'h6) r = RG_REGS;
    else if (a[15:12] == 4'h7) r = RG_CRAM;
    else if (a[15:14] == 2'b10) r = RG_ROMLO;
    else if (a[15:13] == 3'b110) r = RG_ROMSW;
    else if (a[15:12] == 4'hE) r = RG_FWSW;
    else if (a[15:12] == 4'hF) r = RG_FWTOP;
    return r;
  endfunction

  function automatic logic [5:0] swap_bank(input logic [4:0] sel, input logic a12);
    return {sel, a12};
  endfunction

  function automatic logic [1:0] fixed_bank(input logic [15:0] a);
    return a[13:12];
  endfunction

endpackage

// File: rtl/netcart_ctl_regs.sv
module netcart_ctl_regs
  import netcart_pkg::*;
#(
  parameter int VWIN_W = 5,
  parameter int RAM_SEL_W = 3,
  parameter int FW_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 cpu_rnw,
  input  logic                 cpu_en,
  output logic [4:0]           romsw_q,
  output logic [RAM_SEL_W-1:0] cram_q,
  output logic [FW_SEL_W-1:0]  fwsw_q,
  output logic [VWIN_W-1:0]    vwin_q,
  output logic                 wr_commit
);

  logic        en_q;
  logic [15:0] lat_addr;
  logic [7:0]  lat_data;
  logic        lat_rnw;
  logic [2:0]  lat_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_rnw  <= 1'b1;
    end else begin
      en_q <= cpu_en;
      if (cpu_en) begin
        lat_addr <= cpu_addr;
        lat_data <= cpu_wdata;
        lat_rnw  <= cpu_rnw;
      end
    end
  end

  assign lat_idx   = lat_addr[2:0];
  assign wr_commit = en_q && !cpu_en && !lat_rnw && (region_of(lat_addr) == RG_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      romsw_q <= '0;
      cram_q  <= '0;
      fwsw_q  <= '0;
      vwin_q  <= '0;
    end else if (wr_commit) begin
      unique case (lat_idx)
        IDX_VWIN:  vwin_q  <= lat_data[VWIN_W-1:0];
        IDX_ROMSW: romsw_q <= lat_data[5:1];
        IDX_CRAM:  cram_q  <= lat_data[RAM_SEL_W-1:0];
        IDX_FWSW:  fwsw_q  <= lat_data[FW_SEL_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/netcart_addr_decode.sv
module netcart_addr_decode
  import netcart_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int RAM_SEL_W = 3,
  parameter int FW_SEL_W = 3,
  parameter logic [7:0] NOCARD_VAL = 8'hFF
) (
  input  logic [15:0]          cpu_addr,
  input  logic                 cpu_rnw,
  input  logic                 cpu_en,
  input  logic                 card_present,
  input  logic [4:0]           romsw_q,
  input  logic [RAM_SEL_W-1:0] cram_q,
  input  logic [FW_SEL_W-1:0]  fwsw_q,
  output logic [BANK_W-1:0]    bank_out,
  output logic                 card_cs,
  output logic                 card_ram,
  output logic                 fw_cs,
  output logic                 vwin_cs,
  output logic                 reg_cs,
  output logic                 modem_cs,
  output logic [7:0]           rd_data,
  output logic                 rd_oe
);

  localparam logic [BANK_W-1:0] FW_LAST = {BANK_W{1'b1}};

  region_e    rg;
  logic [2:0] idx;
  logic       rom_window;

  assign rg         = region_of(cpu_addr);
  assign idx        = cpu_addr[2:0];
  assign rom_window = (rg == RG_ROMLO) || (rg == RG_ROMSW);

  always_comb begin
    bank_out = '0;
    unique case (rg)
      RG_CRAM:  bank_out = BANK_W'(cram_q);
      RG_ROMLO: bank_out = BANK_W'(fixed_bank(cpu_addr));
      RG_ROMSW: bank_out = BANK_W'(swap_bank(romsw_q, cpu_addr[12]));
      RG_FWSW:  bank_out = BANK_W'(fwsw_q);
      RG_FWTOP: bank_out = FW_LAST;
      default:  bank_out = '0;
    endcase
  end

  assign card_ram = (rg == RG_CRAM);
  assign card_cs  = cpu_en && card_present && ((rg == RG_CRAM) || rom_window);
  assign fw_cs    = cpu_en && ((rg == RG_FWSW) || (rg == RG_FWTOP) || (!card_present && rom_window));
  assign vwin_cs  = cpu_en && (rg == RG_VWIN);
  assign reg_cs   = cpu_en && (rg == RG_REGS);
  assign modem_cs = reg_cs && (idx[2:1] == 2'b00);
  assign rd_oe    = reg_cs && cpu_rnw && (idx == IDX_VWIN);
  assign rd_data  = rd_oe ? (card_present ? 8'h00 : NOCARD_VAL) : 8'h00;

endmodule

// File: rtl/netcart_bank_map.sv
module netcart_bank_map #(
  parameter int BANK_W = 6,
  parameter int VWIN_W = 5,
  parameter int RAM_SEL_W = 3,
  parameter int FW_SEL_W = 3,
  parameter logic [7:0] NOCARD_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rnw,
  input  logic              cpu_en,
  input  logic              card_present,
  output logic [BANK_W-1:0] bank_out,
  output logic              card_cs,
  output logic              card_ram,
  output logic              fw_cs,
  output logic              vwin_cs,
  output logic [VWIN_W-1:0] vwin_bank,
  output logic              reg_cs,
  output logic              modem_cs,
  output logic [7:0]        rd_data,
  output logic              rd_oe
);

  logic [4:0]           romsw_q;
  logic [RAM_SEL_W-1:0] cram_q;
  logic [FW_SEL_W-1:0]  fwsw_q;
  logic                 wr_commit;

  netcart_ctl_regs #(
    .VWIN_W(VWIN_W), .RAM_SEL_W(RAM_SEL_W), .FW_SEL_W(FW_SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .cpu_en(cpu_en), .romsw_q(romsw_q), .cram_q(cram_q),
    .fwsw_q(fwsw_q), .vwin_q(vwin_bank), .wr_commit(wr_commit)
  );

  netcart_addr_decode #(
    .BANK_W(BANK_W), .RAM_SEL_W(RAM_SEL_W), .FW_SEL_W(FW_SEL_W),
    .NOCARD_VAL(NOCARD_VAL)
  ) u_dec (
    .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .cpu_en(cpu_en),
    .card_present(card_present), .romsw_q(romsw_q), .cram_q(cram_q),
    .fwsw_q(fwsw_q), .bank_out(bank_out), .card_cs(card_cs),
    .card_ram(card_ram), .fw_cs(fw_cs), .vwin_cs(vwin_cs), .reg_cs(reg_cs),
    .modem_cs(modem_cs), .rd_data(rd_data), .rd_oe(rd_oe)
  );

endmodule

// File: rtl/netcart_bank_map_chk.sv
module netcart_bank_map_chk #(
  parameter int BANK_W = 6,
  parameter int VWIN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              cpu_en,
  input logic              cpu_rnw,
  input logic              card_present,
  input logic [BANK_W-1:0] bank_out,
  input logic              card_cs,
  input logic              fw_cs,
  input logic              vwin_cs,
  input logic [VWIN_W-1:0] vwin_bank,
  input logic              reg_cs,
  input logic              rd_oe,
  input logic [7:0]        rd_data,
  input logic              wr_commit
);

  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_cs, fw_cs, vwin_cs, reg_cs}));

  a_r8_no_card: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present |-> !card_cs);

  a_r6_top_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_addr[15:12] == 4'hF) |-> (fw_cs && bank_out == {BANK_W{1'b1}}));

  a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (cpu_rnw && ((rd_data == 8'h00) == card_present)));

  a_r11_window: assert property (@(posedge clk) disable iff (!rst_n)
    vwin_cs |-> (cpu_addr[15:11] == 5'b01010));

  a_r12_commit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $fell(cpu_en));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(vwin_bank));

endmodule

bind netcart_bank_map netcart_bank_map_chk #(.BANK_W(BANK_W), .VWIN_W(VWIN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_en(cpu_en),
  .cpu_rnw(cpu_rnw), .card_present(card_present), .bank_out(bank_out),
  .card_cs(card_cs), .fw_cs(fw_cs), .vwin_cs(vwin_cs), .vwin_bank(vwin_bank),
  .reg_cs(reg_cs), .rd_oe(rd_oe), .rd_data(rd_data), .wr_commit(wr_commit)
);

// File: tb/test_netcart_bank_map.sv
module test_netcart_bank_map;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_rnw = 1'b1;
  logic        cpu_en = 1'b0;
  logic        card_present = 1'b1;
  logic [5:0]  bank_out;
  logic        card_cs, card_ram, fw_cs, vwin_cs, reg_cs, modem_cs, rd_oe;
  logic [4:0]  vwin_bank;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  netcart_bank_map i_netcart_bank_map (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .cpu_en(cpu_en), .card_present(card_present),
    .bank_out(bank_out), .card_cs(card_cs), .card_ram(card_ram), .fw_cs(fw_cs),
    .vwin_cs(vwin_cs), .vwin_bank(vwin_bank), .reg_cs(reg_cs),
    .modem_cs(modem_cs), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // {present, addr[15:0], bank[5:0], card_cs, fw_cs, card_ram}
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 16'h7123, 6'd5,  1'b1, 1'b0, 1'b1},
    {1'b1, 16'h8000, 6'd0,  1'b1, 1'b0, 1'b0},
    {1'b1, 16'hA000, 6'd2,  1'b1, 1'b0, 1'b0},
    {1'b1, 16'hB456, 6'd3,  1'b1, 1'b0, 1'b0},
    {1'b1, 16'hC000, 6'd42, 1'b1, 1'b0, 1'b0},
    {1'b1, 16'hD800, 6'd43, 1'b1, 1'b0, 1'b0},
    {1'b1, 16'hE001, 6'd6,  1'b0, 1'b1, 1'b0},
    {1'b1, 16'hF000, 6'd63, 1'b0, 1'b1, 1'b0},
    {1'b1, 16'h5400, 6'd0,  1'b0, 1'b0, 1'b0},
    {1'b0, 16'h7123, 6'd5,  1'b0, 1'b0, 1'b1},
    {1'b0, 16'h9000, 6'd1,  1'b0, 1'b1, 1'b0},
    {1'b0, 16'hC000, 6'd42, 1'b0, 1'b1, 1'b0},
    {1'b0, 16'hD000, 6'd43, 1'b0, 1'b1, 1'b0},
    {1'b0, 16'hE000, 6'd6,  1'b0, 1'b1, 1'b0},
    {1'b0, 16'hFFFF, 6'd63, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [15:0] a, input logic rnw);
    @(negedge clk);
    cpu_addr = a;
    cpu_rnw = rnw;
    cpu_en = 1'b1;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_en = 1'b0;
    cpu_rnw = 1'b1;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_wdata = d;
    cpu_rnw = 1'b0;
    cpu_en = 1'b1;
    @(negedge clk);
    cpu_en = 1'b0;
    @(negedge clk);
    cpu_rnw = 1'b1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every bank
    check("R1 vwin", 32'(vwin_bank), 0);
    probe(16'h7000, 1'b1); check("R1 ram bank", 32'(bank_out), 0);
    probe(16'hE000, 1'b1); check("R1 fw bank", 32'(bank_out), 0);
    probe(16'hC000, 1'b1); check("R1 C000 bank", 32'(bank_out), 0);
    probe(16'hD000, 1'b1); check("R1 D000 bank", 32'(bank_out), 1);
    idle();

    // R9: writes through different mirrors; R3 ignored bits set in 0xEB
    bus_write(16'h6A3B, 8'hEB);
    bus_write(16'h6FFC, 8'hFD);
    bus_write(16'h6005, 8'h0E);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      card_present = VEC[i][25];
      probe(VEC[i][24:9], 1'b1);
      check("R2/R3/R4/R5/R6 bank", 32'(bank_out), 32'(VEC[i][8:3]));
      check("R7/R8 card_cs", 32'(card_cs), 32'(VEC[i][2]));
      check("R7/R8 fw_cs", 32'(fw_cs), 32'(VEC[i][1]));
      check("R4 card_ram", 32'(card_ram), 32'(VEC[i][0]));
    end
    idle();

    // R10: status read, with a mirror
    card_present = 1'b1;
    probe(16'h6002, 1'b1);
    check("R10 oe present", 32'(rd_oe), 1);
    check("R10 data present", 32'(rd_data), 32'h00);
    card_present = 1'b0;
    probe(16'h6FF2, 1'b1);
    check("R10 oe absent", 32'(rd_oe), 1);
    check("R10 data absent", 32'(rd_data), 32'hFF);
    probe(16'h6003, 1'b1);
    check("R10 oe other idx", 32'(rd_oe), 0);
    card_present = 1'b1;

    // R13: serial selects
    probe(16'h6001, 1'b1); check("R13 idx1", 32'(modem_cs), 1);
    probe(16'h6808, 1'b1); check("R13 idx0 mirror", 32'(modem_cs), 1);
    probe(16'h6002, 1'b1); check("R13 idx2", 32'(modem_cs), 0);

    // R11: window edges
    probe(16'h57FF, 1'b1); check("R11 57FF", 32'(vwin_cs), 1);
    probe(16'h5800, 1'b1); check("R11 5800", 32'(vwin_cs), 0);
    idle();

    // R12/R11: held enable does not commit; falling enable does
    @(negedge clk);
    cpu_addr = 16'h6A0A; cpu_wdata = 8'h1D; cpu_rnw = 1'b0; cpu_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 held no commit", 32'(vwin_bank), 0);
    cpu_en = 1'b0;
    @(negedge clk);
    check("R11 vwin written", 32'(vwin_bank), 32'h1D);
    cpu_rnw = 1'b1;

    // R12: read cycle changes nothing
    @(negedge clk);
    cpu_addr = 16'h6004; cpu_wdata = 8'h02; cpu_rnw = 1'b1; cpu_en = 1'b1;
    @(negedge clk);
    cpu_en = 1'b0;
    @(negedge clk);
    probe(16'h7000, 1'b1);
    check("R12 read no write", 32'(bank_out), 5);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule